// File: doc/BRIEF.md
# Mirrored Dual-Port Level-One Data Cache

This block is a direct-mapped level-one data cache that serves two requests per cycle. It keeps two identical copies of its tag, valid and data storage. Each copy has one read port and one write port. Port A reads copy 0 and port B reads copy 1, so two loads proceed in parallel. Every write (a refill line or a store word) goes to both copies in the same cycle, so the copies never differ.

Stores are write-through: each accepted store is sent to the next level one cycle after it is accepted. A store that misses allocates its line, so write-allocate applies. On a miss the cache stalls both ports and raises a line request. When the line arrives, the cache writes it into both copies and answers the waiting request.

The bench stands in for the next level and answers each line request after a fixed delay. Only one store can be accepted per cycle. When both ports present a store, port A's store is taken first and port B's follows.

Top module: `dual_copy_dcache`

## Requirements
- R1: With the defaults, capacity is 16384 bytes in 32-byte lines, direct-mapped. Address bits [4:3] pick the 64-bit word and bits [13:5] pick the line; the bits above bit 13 form the tag. Address bits [2:0] are ignored. In a refill line, word k sits at bits [64k+63:64k].
- R2: A load that hits is answered one cycle after it is accepted, with the rsp_valid and rsp_hit flags set and the stored word on the data output.
- R3: Two loads, one per port, are accepted and answered in the same cycle; each port reads its own copy.
- R4: A store updates both copies, so a later load of that word on either port returns the stored value.
- R5: Every accepted store appears on the write-through outputs one cycle after acceptance, with its address (bits [2:0] cleared) and data, in acceptance order.
- R6: On a load miss, fill_req is raised with a line-aligned address and held until fill_valid. If the next level answers six cycles after first seeing fill_req, the response comes eight cycles after acceptance with rsp_hit low. The line is then resident.
- R7: A store miss fetches the line, merges the store word into it, writes the result into both copies and answers with rsp_hit low. Later loads of the line hit.
- R8: When both ports present a store in the same cycle, port A is accepted and b_stall is high. Port B is accepted one cycle later.
- R9: When a load and a store to the same word are accepted in the same cycle, on opposite ports, the load returns the new store data.
- R10: While a refill is outstanding, both ports stall. When port A misses, port B is stalled in that cycle and is accepted once the refill has completed.
- R11: A line with a different tag at the same index misses and replaces the resident line.
- R12: After reset no response, refill request or write-through is active, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_req_valid | input | 1 | Port A request present |
| a_req_store | input | 1 | Port A request is a store |
| a_req_addr | input | ADDR_W | Port A byte address |
| a_req_wdata | input | DATA_W | Port A store data |
| a_stall | output | 1 | Port A request not taken this cycle |
| a_rsp_valid | output | 1 | Port A response valid |
| a_rsp_hit | output | 1 | Port A response served without refill |
| a_rsp_data | output | DATA_W | Port A response word |
| b_req_valid | input | 1 | Port B request present |
| b_req_store | input | 1 | Port B request is a store |
| b_req_addr | input | ADDR_W | Port B byte address |
| b_req_wdata | input | DATA_W | Port B store data |
| b_stall | output | 1 | Port B request not taken this cycle |
| b_rsp_valid | output | 1 | Port B response valid |
| b_rsp_hit | output | 1 | Port B response served without refill |
| b_rsp_data | output | DATA_W | Port B response word |
| fill_req | output | 1 | Line request to the next level |
| fill_addr | output | ADDR_W | Line-aligned request address |
| fill_valid | input | 1 | Requested line present |
| fill_line | input | LINE_BYTES*8 | Returned line |
| wt_valid | output | 1 | Write-through store valid |
| wt_addr | output | ADDR_W | Write-through word address |
| wt_data | output | DATA_W | Write-through data |

## Verification
The hardest case to reach is a refill that runs while the other port already holds a request. The same applies to a store that misses while both ports carry stores, because port B then waits through the whole refill. The bench issues paired requests with a chosen hit or miss on each port, using a small configuration with eight lines. It predicts from its own residency model which port is accepted in which cycle. Sweeps over every word, with load/store pairs on the same address, cover same-cycle forwarding and the agreement of the two copies.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_WAIT = 1'b1
  } fill_state_e;

  localparam logic PORT_A = 1'b0;
  localparam logic PORT_B = 1'b1;
endpackage

// File: rtl/dcc_copy.sv
module dcc_copy #(
  parameter int unsigned LINES  = 512,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned TAG_W  = 18,
  parameter int unsigned LINE_W = 256,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_line_en,
  input  logic              wr_word_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [WSEL_W-1:0] wr_sel,
  input  logic [DATA_W-1:0] wr_word
);
  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  valid_d;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];

  always_comb begin
    valid_d = valid_q;
    if (wr_line_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_line_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_line;
    end else if (wr_word_en) begin
      data_q[wr_idx][int'(wr_sel)*DATA_W +: DATA_W] <= wr_word;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_line  = data_q[rd_idx];

  // R4: a copy never takes a line refill and a store word in one cycle
  a_r4_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_line_en && wr_word_en));

  // R6: a written line is valid from the next cycle
  a_r6_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_line_en |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/dcc_fill_ctrl.sv
module dcc_fill_ctrl
  import dcc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned TAG_W  = 18,
  parameter int unsigned LINE_W = 256,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned WSEL_W = 2,
  parameter int unsigned OFF_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_port,
  input  logic              start_store,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_line,
  output logic              busy,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [LINE_W-1:0] wr_line,
  output logic              done_port,
  output logic [DATA_W-1:0] done_word
);
  localparam int unsigned WA_W  = ADDR_W - OFF_W;
  localparam int unsigned LO_W  = OFF_W + WSEL_W;

  fill_state_e       state_q, state_d;
  logic              load_en;
  logic              port_q, store_q;
  logic [WA_W-1:0]   waddr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [WSEL_W-1:0] sel;

  always_comb begin
    state_d = state_q;
    load_en = 1'b0;
    case (state_q)
      FILL_IDLE: if (start) begin
        state_d = FILL_WAIT;
        load_en = 1'b1;
      end
      FILL_WAIT: if (fill_valid) state_d = FILL_IDLE;
      default:   state_d = FILL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FILL_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      port_q  <= start_port;
      store_q <= start_store;
      waddr_q <= start_addr[ADDR_W-1:OFF_W];
      wdata_q <= start_wdata;
    end
  end

  assign busy      = (state_q == FILL_WAIT);
  assign fill_req  = busy;
  assign fill_addr = {waddr_q[WA_W-1:WSEL_W], {LO_W{1'b0}}};
  assign sel       = waddr_q[WSEL_W-1:0];
  assign wr_en     = busy && fill_valid;
  assign wr_idx    = waddr_q[WSEL_W +: IDX_W];
  assign wr_tag    = waddr_q[WA_W-1 -: TAG_W];
  assign done_port = port_q;

  always_comb begin
    wr_line = fill_line;
    if (store_q) wr_line[int'(sel)*DATA_W +: DATA_W] = wdata_q;
  end

  assign done_word = store_q ? wdata_q : fill_line[int'(sel)*DATA_W +: DATA_W];

  // R6: the line request stays up until the line arrives
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !fill_valid) |=> fill_req);

  // R10: no new miss is started while a refill is outstanding
  a_r10_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

  // R6: the controller is free again right after the line is written
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !busy);
endmodule

// File: rtl/dual_copy_dcache.sv
module dual_copy_dcache
  import dcc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CAP_BYTES  = 16384,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned DATA_W     = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    a_req_valid,
  input  logic                    a_req_store,
  input  logic [ADDR_W-1:0]       a_req_addr,
  input  logic [DATA_W-1:0]       a_req_wdata,
  output logic                    a_stall,
  output logic                    a_rsp_valid,
  output logic                    a_rsp_hit,
  output logic [DATA_W-1:0]       a_rsp_data,
  input  logic                    b_req_valid,
  input  logic                    b_req_store,
  input  logic [ADDR_W-1:0]       b_req_addr,
  input  logic [DATA_W-1:0]       b_req_wdata,
  output logic                    b_stall,
  output logic                    b_rsp_valid,
  output logic                    b_rsp_hit,
  output logic [DATA_W-1:0]       b_rsp_data,
  output logic                    fill_req,
  output logic [ADDR_W-1:0]       fill_addr,
  input  logic                    fill_valid,
  input  logic [LINE_BYTES*8-1:0] fill_line,
  output logic                    wt_valid,
  output logic [ADDR_W-1:0]       wt_addr,
  output logic [DATA_W-1:0]       wt_data
);
  localparam int unsigned WORD_BYTES = DATA_W / 8;
  localparam int unsigned WORDS      = LINE_BYTES / WORD_BYTES;
  localparam int unsigned LINES      = CAP_BYTES / LINE_BYTES;
  localparam int unsigned LINE_W     = LINE_BYTES * 8;
  localparam int unsigned OFF_W      = $clog2(WORD_BYTES);
  localparam int unsigned WSEL_W     = $clog2(WORDS);
  localparam int unsigned IDX_W      = $clog2(LINES);
  localparam int unsigned LO_W       = OFF_W + WSEL_W;
  localparam int unsigned TAG_W      = ADDR_W - IDX_W - LO_W;
  localparam int unsigned NCOPY      = 2;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_meta, rst_q} <= 2'b00;
    else        {rst_meta, rst_q} <= {1'b1, rst_meta};
  end

  // address decode per port
  logic [IDX_W-1:0]  idx_a, idx_b;
  logic [TAG_W-1:0]  tag_a, tag_b;
  logic [WSEL_W-1:0] sel_a, sel_b;
  logic [ADDR_W-1:OFF_W] wa_a, wa_b;
  logic unused_low;
  assign idx_a = a_req_addr[LO_W +: IDX_W];
  assign idx_b = b_req_addr[LO_W +: IDX_W];
  assign tag_a = a_req_addr[ADDR_W-1 -: TAG_W];
  assign tag_b = b_req_addr[ADDR_W-1 -: TAG_W];
  assign sel_a = a_req_addr[OFF_W +: WSEL_W];
  assign sel_b = b_req_addr[OFF_W +: WSEL_W];
  assign wa_a  = a_req_addr[ADDR_W-1:OFF_W];
  assign wa_b  = b_req_addr[ADDR_W-1:OFF_W];
  assign unused_low = ^{a_req_addr[OFF_W-1:0], b_req_addr[OFF_W-1:0]};

  // the two mirrored copies
  logic [NCOPY-1:0]  cp_valid;
  logic [TAG_W-1:0]  cp_tag  [NCOPY];
  logic [LINE_W-1:0] cp_line [NCOPY];
  logic              fill_we, st_we;
  logic [IDX_W-1:0]  fill_idx, st_idx, wr_idx;
  logic [TAG_W-1:0]  fill_tag;
  logic [LINE_W-1:0] fill_merged;
  logic [WSEL_W-1:0] st_sel;
  logic [DATA_W-1:0] st_word;

  assign wr_idx = fill_we ? fill_idx : st_idx;

  for (genvar g = 0; g < NCOPY; g++) begin : g_copy
    dcc_copy #(
      .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W),
      .LINE_W(LINE_W), .DATA_W(DATA_W), .WSEL_W(WSEL_W)
    ) u_copy (
      .clk(clk), .rst_n(rst_q),
      .rd_idx((g == 0) ? idx_a : idx_b),
      .rd_valid(cp_valid[g]), .rd_tag(cp_tag[g]), .rd_line(cp_line[g]),
      .wr_line_en(fill_we), .wr_word_en(st_we), .wr_idx(wr_idx),
      .wr_tag(fill_tag), .wr_line(fill_merged), .wr_sel(st_sel), .wr_word(st_word)
    );
  end

  // hit, acceptance and stall
  logic hit_a, hit_b, acc_a, acc_b, block_b, miss_a, miss_b, busy;
  logic sta_a, sta_b, fwd_a, fwd_b;
  logic [DATA_W-1:0] word_a, word_b;

  assign hit_a   = cp_valid[0] && (cp_tag[0] == tag_a);
  assign hit_b   = cp_valid[1] && (cp_tag[1] == tag_b);
  assign acc_a   = a_req_valid && !busy;
  assign block_b = busy || (a_req_valid && a_req_store && b_req_store) ||
                   (a_req_valid && !hit_a);
  assign acc_b   = b_req_valid && !block_b;
  assign a_stall = a_req_valid && busy;
  assign b_stall = b_req_valid && block_b;
  assign miss_a  = acc_a && !hit_a;
  assign miss_b  = acc_b && !hit_b;
  assign sta_a   = acc_a && a_req_store;
  assign sta_b   = acc_b && b_req_store;
  assign fwd_a   = acc_a && !a_req_store && sta_b && (wa_a == wa_b);
  assign fwd_b   = acc_b && !b_req_store && sta_a && (wa_a == wa_b);
  assign word_a  = cp_line[0][int'(sel_a)*DATA_W +: DATA_W];
  assign word_b  = cp_line[1][int'(sel_b)*DATA_W +: DATA_W];

  // store hit: one word written to both copies
  assign st_we   = (sta_a && hit_a) || (sta_b && hit_b);
  assign st_idx  = sta_a ? idx_a : idx_b;
  assign st_sel  = sta_a ? sel_a : sel_b;
  assign st_word = sta_a ? a_req_wdata : b_req_wdata;

  // refill sequencing
  logic              done_port;
  logic [DATA_W-1:0] done_word;

  dcc_fill_ctrl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W),
    .DATA_W(DATA_W), .WSEL_W(WSEL_W), .OFF_W(OFF_W)
  ) u_fill (
    .clk(clk), .rst_n(rst_q),
    .start(miss_a || miss_b),
    .start_port(miss_a ? PORT_A : PORT_B),
    .start_store(miss_a ? a_req_store : b_req_store),
    .start_addr(miss_a ? a_req_addr : b_req_addr),
    .start_wdata(miss_a ? a_req_wdata : b_req_wdata),
    .fill_valid(fill_valid), .fill_line(fill_line),
    .busy(busy), .fill_req(fill_req), .fill_addr(fill_addr),
    .wr_en(fill_we), .wr_idx(fill_idx), .wr_tag(fill_tag), .wr_line(fill_merged),
    .done_port(done_port), .done_word(done_word)
  );

  // responses: next state
  logic              a_vld_d, a_hit_d, b_vld_d, b_hit_d, wt_vld_d;
  logic [DATA_W-1:0] a_dat_d, b_dat_d, wt_dat_d;
  logic [ADDR_W-1:0] wt_adr_d;

  always_comb begin
    a_hit_d = acc_a && hit_a;
    b_hit_d = acc_b && hit_b;
    a_vld_d = a_hit_d || (fill_we && (done_port == PORT_A));
    b_vld_d = b_hit_d || (fill_we && (done_port == PORT_B));
    if (fill_we)          a_dat_d = done_word;
    else if (a_req_store) a_dat_d = a_req_wdata;
    else if (fwd_a)       a_dat_d = b_req_wdata;
    else                  a_dat_d = word_a;
    if (fill_we)          b_dat_d = done_word;
    else if (b_req_store) b_dat_d = b_req_wdata;
    else if (fwd_b)       b_dat_d = a_req_wdata;
    else                  b_dat_d = word_b;
    wt_vld_d = sta_a || sta_b;
    wt_adr_d = {(sta_a ? wa_a : wa_b), {OFF_W{1'b0}}};
    wt_dat_d = sta_a ? a_req_wdata : b_req_wdata;
  end

  // responses: registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      a_rsp_valid <= 1'b0;
      a_rsp_hit   <= 1'b0;
      b_rsp_valid <= 1'b0;
      b_rsp_hit   <= 1'b0;
      wt_valid    <= 1'b0;
    end else begin
      a_rsp_valid <= a_vld_d;
      a_rsp_hit   <= a_hit_d;
      b_rsp_valid <= b_vld_d;
      b_rsp_hit   <= b_hit_d;
      wt_valid    <= wt_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (a_vld_d)  a_rsp_data <= a_dat_d;
    if (b_vld_d)  b_rsp_data <= b_dat_d;
    if (wt_vld_d) begin
      wt_addr <= wt_adr_d;
      wt_data <= wt_dat_d;
    end
  end

  // R3: both copies hold the same content for any index read on both ports
  a_r3_copies_agree: assert property (@(posedge clk) disable iff (!rst_q)
    (idx_a == idx_b) |-> (cp_valid[0] == cp_valid[1]) &&
      (!cp_valid[0] || ((cp_tag[0] == cp_tag[1]) && (cp_line[0] == cp_line[1]))));

  // R2: an accepted hit on port A answers in the next cycle
  a_r2_hit_answer: assert property (@(posedge clk) disable iff (!rst_q)
    (acc_a && hit_a) |=> (a_rsp_valid && a_rsp_hit));

  // R5: each accepted store shows up on the write-through outputs
  a_r5_wt_follows: assert property (@(posedge clk) disable iff (!rst_q)
    (sta_a || sta_b) |=> wt_valid);

  // R8: two stores at once hold port B
  a_r8_store_pair: assert property (@(posedge clk) disable iff (!rst_q)
    (a_req_valid && a_req_store && b_req_valid && b_req_store) |-> b_stall);

  // R10: an outstanding refill stalls port A
  a_r10_busy_stall: assert property (@(posedge clk) disable iff (!rst_q)
    (fill_req && a_req_valid) |-> a_stall);

  // R6: a completed line write always produces a response
  a_r6_fill_answers: assert property (@(posedge clk) disable iff (!rst_q)
    fill_we |=> (a_rsp_valid || b_rsp_valid));
endmodule

// File: tb/dual_copy_dcache_bench.sv
module dual_copy_dcache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 12;
  localparam int CAP = 256;
  localparam int DW  = 64;
  localparam int LW  = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          a_req_valid = 0, a_req_store = 0, b_req_valid = 0, b_req_store = 0;
  logic [AW-1:0] a_req_addr = '0, b_req_addr = '0;
  logic [DW-1:0] a_req_wdata = '0, b_req_wdata = '0;
  logic          a_stall, a_rsp_valid, a_rsp_hit, b_stall, b_rsp_valid, b_rsp_hit;
  logic [DW-1:0] a_rsp_data, b_rsp_data;
  logic          fill_req, wt_valid;
  logic          fill_valid = 0;
  logic [LW-1:0] fill_line = '0;
  logic [AW-1:0] fill_addr, wt_addr;
  logic [DW-1:0] wt_data;

  dual_copy_dcache #(.ADDR_W(AW), .CAP_BYTES(CAP), .LINE_BYTES(32), .DATA_W(DW)) u_dual_copy_dcache (
    .clk(clk), .rst_n(rst_n),
    .a_req_valid(a_req_valid), .a_req_store(a_req_store), .a_req_addr(a_req_addr),
    .a_req_wdata(a_req_wdata), .a_stall(a_stall), .a_rsp_valid(a_rsp_valid),
    .a_rsp_hit(a_rsp_hit), .a_rsp_data(a_rsp_data),
    .b_req_valid(b_req_valid), .b_req_store(b_req_store), .b_req_addr(b_req_addr),
    .b_req_wdata(b_req_wdata), .b_stall(b_stall), .b_rsp_valid(b_rsp_valid),
    .b_rsp_hit(b_rsp_hit), .b_rsp_data(b_rsp_data),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_line(fill_line),
    .wt_valid(wt_valid), .wt_addr(wt_addr), .wt_data(wt_data)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  logic [DW-1:0] mem    [512];   // expected contents
  logic [DW-1:0] nl_mem [512];   // next-level memory, fed by write-through
  logic [3:0]    mtag   [8];
  logic          mval   [8];

  int            ra_cnt = 0, rb_cnt = 0, ra_cyc = 0, rb_cyc = 0;
  logic [DW-1:0] ra_data, rb_data;
  logic          ra_hit, rb_hit;
  logic [AW-1:0] wt_la [64];
  logic [DW-1:0] wt_ld [64];
  int            wt_n = 0;
  int            rcnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // response, write-through and next-level models
  always @(negedge clk) begin
    if (a_rsp_valid) begin ra_cnt++; ra_data = a_rsp_data; ra_hit = a_rsp_hit; ra_cyc = cyc; end
    if (b_rsp_valid) begin rb_cnt++; rb_data = b_rsp_data; rb_hit = b_rsp_hit; rb_cyc = cyc; end
    if (wt_valid) begin
      if (wt_n < 64) begin wt_la[wt_n] = wt_addr; wt_ld[wt_n] = wt_data; end
      wt_n++;
      nl_mem[wt_addr[11:3]] = wt_data;
    end
    if (fill_req) begin
      rcnt++;
      if (rcnt == 7) begin
        check("R6", "fill_addr low bits", {59'd0, fill_addr[4:0]}, 64'd0);
        for (int k = 0; k < 4; k++)
          fill_line[k*64 +: 64] = nl_mem[{fill_addr[11:5], 2'(k)}];
        fill_valid = 1'b1;
      end else fill_valid = 1'b0;
    end else begin
      rcnt = 0;
      fill_valid = 1'b0;
    end
  end

  function automatic logic [AW-1:0] mk(input int t, input int i, input int w);
    return {t[3:0], i[2:0], w[1:0], 3'b000};
  endfunction

  task automatic run(input string req,
                     input bit av, input bit ast, input logic [AW-1:0] aad, input logic [DW-1:0] awd,
                     input bit bv, input bit bst, input logic [AW-1:0] bad, input logic [DW-1:0] bwd);
    bit hit_a, hit_b, same_b, pa, pb, sa, sb;
    logic [DW-1:0] exp_a, exp_b;
    int acc_a, acc_b, ra0, rb0, wt0, exp_diff, n;
    hit_a = 0; hit_b = 0; exp_a = '0; exp_b = '0; exp_diff = 0;
    acc_a = 0; acc_b = 0;
    // predict port A, then apply A to the model, then predict port B
    if (av) begin
      hit_a = mval[aad[7:5]] && (mtag[aad[7:5]] == aad[11:8]);
      same_b = bv && hit_a && !(ast && bst);
      if (ast) exp_a = awd;
      else if (same_b && bst && (aad[11:3] == bad[11:3])) exp_a = bwd;
      else exp_a = mem[aad[11:3]];
      exp_diff = !hit_a ? 8 : ((ast && bst) ? 1 : 0);
      mval[aad[7:5]] = 1'b1; mtag[aad[7:5]] = aad[11:8];
      if (ast) mem[aad[11:3]] = awd;
    end
    if (bv) begin
      hit_b = mval[bad[7:5]] && (mtag[bad[7:5]] == bad[11:8]);
      exp_b = bst ? bwd : mem[bad[11:3]];
      mval[bad[7:5]] = 1'b1; mtag[bad[7:5]] = bad[11:8];
      if (bst) mem[bad[11:3]] = bwd;
    end
    ra0 = ra_cnt; rb0 = rb_cnt; wt0 = wt_n;
    pa = av; pb = bv;
    while (pa || pb) begin
      @(negedge clk);
      a_req_valid = pa; a_req_store = ast; a_req_addr = aad; a_req_wdata = awd;
      b_req_valid = pb; b_req_store = bst; b_req_addr = bad; b_req_wdata = bwd;
      #1;
      sa = a_stall; sb = b_stall;
      if (pa && !sa) begin acc_a = cyc; end
      if (pb && !sb) begin acc_b = cyc; end
      @(posedge clk);
      if (pa && !sa) pa = 0;
      if (pb && !sb) pb = 0;
    end
    @(negedge clk);
    a_req_valid = 0; b_req_valid = 0;
    repeat (12) @(negedge clk);
    if (av) begin
      check(req, "A response count", 64'(ra_cnt - ra0), 64'd1);
      check(req, "A data", ra_data, exp_a);
      check(req, "A hit flag", {63'd0, ra_hit}, {63'd0, hit_a});
      check(req, "A latency", 64'(ra_cyc - acc_a), hit_a ? 64'd1 : 64'd8);
    end
    if (bv) begin
      check(req, "B response count", 64'(rb_cnt - rb0), 64'd1);
      check(req, "B data", rb_data, exp_b);
      check(req, "B hit flag", {63'd0, rb_hit}, {63'd0, hit_b});
      check(req, "B latency", 64'(rb_cyc - acc_b), hit_b ? 64'd1 : 64'd8);
    end
    if (av && bv) check(req, "B accept offset", 64'(acc_b - acc_a), 64'(exp_diff));
    n = wt0;
    check(req, "write-through count", 64'(wt_n - wt0), 64'((av && ast) + (bv && bst)));
    if (av && ast && n < 64) begin
      check(req, "write-through A addr", {52'd0, wt_la[n]}, {52'd0, aad[11:3], 3'b000});
      check(req, "write-through A data", wt_ld[n], awd);
      n++;
    end
    if (bv && bst && n < 64) begin
      check(req, "write-through B addr", {52'd0, wt_la[n]}, {52'd0, bad[11:3], 3'b000});
      check(req, "write-through B data", wt_ld[n], bwd);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    for (int w = 0; w < 512; w++) begin
      mem[w]    = {32'hC0DE_0000 + 32'(w), 32'(w) * 32'h9E37_79B1};
      nl_mem[w] = mem[w];
    end
    for (int i = 0; i < 8; i++) begin mval[i] = 1'b0; mtag[i] = '0; end

    repeat (3) @(negedge clk);
    check("R12", "a_rsp_valid in reset", {63'd0, a_rsp_valid}, 64'd0);
    check("R12", "b_rsp_valid in reset", {63'd0, b_rsp_valid}, 64'd0);
    check("R12", "fill_req in reset", {63'd0, fill_req}, 64'd0);
    check("R12", "wt_valid in reset", {63'd0, wt_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12", "fill_req after reset", {63'd0, fill_req}, 64'd0);

    // first access after reset must miss
    run("R12", 1, 0, mk(0, 0, 0), '0, 0, 0, '0, '0);
    // fill every line with tag 0, alternating ports
    for (int i = 1; i < 8; i++) begin
      if (i % 2 == 0) run("R6", 1, 0, mk(0, i, i % 4), '0, 0, 0, '0, '0);
      else            run("R6", 0, 0, '0, '0, 1, 0, mk(0, i, i % 4), '0);
    end
    run("R2", 1, 0, mk(0, 5, 2), '0, 0, 0, '0, '0);
    // field decode over every word
    for (int w = 0; w < 32; w++)
      run("R1", w % 2 == 0, 0, mk(0, w / 4, w % 4) | 12'h5, '0,
                w % 2 == 1, 0, mk(0, w / 4, w % 4) | 12'h3, '0);
    // paired loads
    for (int w = 0; w < 32; w++)
      run("R3", 1, 0, mk(0, w / 4, w % 4), '0, 1, 0, mk(0, (31 - w) / 4, (31 - w) % 4), '0);
    // same-cycle store/load on one word, then read through the other copy
    for (int w = 0; w < 32; w++) begin
      if (w % 2 == 0) begin
        run("R9", 1, 1, mk(0, w / 4, w % 4), 64'hA000_0000_0000_0000 | 64'(w), 1, 0, mk(0, w / 4, w % 4), '0);
        run("R4", 1, 0, mk(0, w / 4, w % 4), '0, 1, 0, mk(0, w / 4, w % 4), '0);
      end else begin
        run("R9", 1, 0, mk(0, w / 4, w % 4), '0, 1, 1, mk(0, w / 4, w % 4), 64'hB000_0000_0000_0000 | 64'(w));
        run("R4", 1, 0, mk(0, w / 4, w % 4), '0, 0, 0, '0, '0);
      end
    end
    run("R5", 0, 0, '0, '0, 1, 1, mk(0, 6, 3), 64'h5555_0000_1111_2222);
    for (int k = 0; k < 4; k++)
      run("R8", 1, 1, mk(0, k, 1), 64'hC100 + 64'(k), 1, 1, mk(0, k + 4, 2), 64'hC200 + 64'(k));
    // store miss with allocate
    run("R7", 1, 1, mk(2, 3, 1), 64'hDEAD_BEEF_0000_0007, 0, 0, '0, '0);
    run("R7", 1, 0, mk(2, 3, 2), '0, 1, 0, mk(2, 3, 1), '0);
    // conflicting tags at one index
    run("R11", 1, 0, mk(0, 3, 0), '0, 0, 0, '0, '0);
    run("R11", 0, 0, '0, '0, 1, 0, mk(2, 3, 1), '0);
    // port B waits behind a refill
    run("R10", 1, 0, mk(5, 4, 0), '0, 1, 0, mk(0, 1, 0), '0);
    run("R10", 1, 1, mk(6, 5, 1), 64'h6666_0000_0000_0001, 1, 1, mk(0, 0, 0), 64'h7777);
    run("R10", 1, 0, mk(0, 2, 3), '0, 1, 0, mk(7, 2, 3), '0);

    done = 1;
    finish_up();
  end
endmodule